// File: doc/BRIEF.md
# Hot-Swap Start-Up and Power-Good Sequencer

This block is the digital controller behind a hot-swap front end. Comparator results arrive as single-bit flags: supply lockout clear, undervoltage, overvoltage, gate fully enhanced, drain pulled low, current limit engaged and severe short. The block decides when the external pass switch may conduct. After turn-on it raises two power-good outputs in sequence. It then watches a power-good input from the downstream converter. When a fault ends conduction, it waits before it retries.

Every delay is a whole multiple of one programmable nominal delay `nominal`, counted in clock cycles. Start-up and the first power-good use 1×. The gap between the two power-good outputs uses 2×. The power-good-input watchdog uses 4×. The retry wait is 1× after undervoltage or power-bad and 4× after overcurrent. An overvoltage fault has no timed wait. The circuit-breaker time `CB_TICKS` is a separate count in clock cycles. `nominal` must be at least 1.

Top module: `hotswap_seq`

## Requirements
- R1: During reset, and after it, `gate_en`, `pg1`, `pg2` and all fault pulses are low. The on bit takes the level of `on_in` N cycles after reset is released. With every condition good and `on_in` high through reset, `gate_en` rises exactly 2N+1 cycles after reset is released. With `on_in` low, the gate stays off until `on_in` rises.
- R2: A start-up wait of N cycles is required before the gate turns on. The wait needs `uvlo_ok` high, `uv_det` and `ov_det` low, `disable_in` low and the on bit set. If any of these is lost during the wait, the block returns to off and the full wait starts again. With `uvlo_ok` low, the gate stays off indefinitely.
- R3: A rising edge on `on_in` starts a start-up, and `gate_en` rises N+1 cycles after the edge is applied. A falling edge turns the gate off at the next clock and clears both power-good outputs. A falling edge reports no fault.
- R4: Once `gate_high` and `drain_low` are both seen while ramping, `pg1` rises N+1 cycles after they are applied.
- R5: `pg2` rises 2N cycles after `pg1`, and `pg2` is never high while `pg1` is low.
- R6: After `pg2` rises, a watchdog of 4N cycles runs. If `pgood_in_n` is low during the watchdog, the gate stays on. If `pgood_in_n` is still high when 4N cycles have elapsed, the gate turns off, `flt_pbad` pulses and both power-good outputs clear.
- R7: Current limit held for `CB_TICKS` consecutive cycles trips the breaker: `flt_oc` pulses and the gate turns off. A shorter current-limit episode has no effect, and the breaker count restarts from zero.
- R8: `short_det` turns the gate off at the next clock. In the same cycle `gate_fast_off` and `flt_oc` pulse and both power-good outputs clear.
- R9: After an overcurrent fault, the gate turns back on 4N cycles after the fault pulse.
- R10: Undervoltage or loss of `uvlo_ok` while conducting does three things: `flt_uv` pulses, both power-good outputs clear, and the gate retries N cycles after the pulse if conditions are good by then. A power-bad fault retries after N cycles in the same way.
- R11: Overvoltage while conducting turns the gate off, pulses `flt_ov` and leaves `pg1` and `pg2` unchanged. The gate turns on again at the first clock after `ov_det` goes low.
- R12: `disable_in` high turns the gate off at the next clock, clears both power-good outputs and reports no fault. After `disable_in` is released, `gate_en` rises N+1 cycles later.
- R13: Each fault output is a single-cycle pulse, and at most one fault output is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| uvlo_ok | input | 1 | Supply lockout clear |
| uv_det | input | 1 | Undervoltage comparator |
| ov_det | input | 1 | Overvoltage comparator |
| gate_high | input | 1 | Gate fully enhanced |
| drain_low | input | 1 | Drain close to the negative rail |
| ilim_act | input | 1 | Current limit engaged |
| short_det | input | 1 | Severe short comparator |
| on_in | input | 1 | On control; edges request on/off |
| disable_in | input | 1 | High forces the switch off |
| pgood_in_n | input | 1 | Downstream power good, low = good |
| nominal | input | CW | Nominal delay N in clock cycles (at least 1) |
| gate_en | output | 1 | Pass switch gate drive enable |
| gate_fast_off | output | 1 | Fast pull-down request pulse |
| pg1 | output | 1 | First power-good |
| pg2 | output | 1 | Second power-good |
| flt_ov | output | 1 | Overvoltage fault pulse |
| flt_uv | output | 1 | Undervoltage fault pulse |
| flt_oc | output | 1 | Overcurrent fault pulse |
| flt_pbad | output | 1 | Power-bad fault pulse |

## Verification
The assertions check the cycle-level invariants on every cycle. A gate turn-on must follow a cycle in which every enabling condition held, and `pg2` never stands without `pg1`. Fault pulses are single and exclusive, overvoltage keeps the power-good state, and disable always removes the gate. Only the bench scenarios can show the exact 1×, 2× and 4× delay lengths. The same applies to the breaker's length threshold and its restart after a short episode, and to the retry delay chosen for each fault type. Each of these is measured as an interval at the ports, with N drawn at random.

// File: rtl/hotswap_seq.sv
module hotswap_seq #(
  parameter int CW = 16,
  parameter int CB_TICKS = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          uvlo_ok,
  input  logic          uv_det,
  input  logic          ov_det,
  input  logic          gate_high,
  input  logic          drain_low,
  input  logic          ilim_act,
  input  logic          short_det,
  input  logic          on_in,
  input  logic          disable_in,
  input  logic          pgood_in_n,
  input  logic [CW-1:0] nominal,
  output logic          gate_en,
  output logic          gate_fast_off,
  output logic          pg1,
  output logic          pg2,
  output logic          flt_ov,
  output logic          flt_uv,
  output logic          flt_oc,
  output logic          flt_pbad
);
  localparam int TW  = CW + 2;
  localparam int CBW = $clog2(CB_TICKS + 1);

  typedef enum logic [2:0] {
    S_OFF, S_START, S_RAMP, S_PG1W, S_PG2W, S_PGIC, S_ON, S_RETRY
  } state_t;

  typedef enum logic [1:0] {RK_1X, RK_4X, RK_OV} rkind_t;

  state_t         st;
  rkind_t         rk;
  logic [TW-1:0]  tcnt, lim;
  logic [CBW-1:0] cb;
  logic           boot, on_bit, on_q;

  wire on_rise    = !boot && on_in && !on_q;
  wire on_fall    = !boot && !on_in && on_q;
  wire on_eff     = on_rise | (on_bit & ~on_fall);
  wire off_req    = disable_in | ~on_eff;
  wire supply_bad = ~uvlo_ok | uv_det;
  wire ok         = ~off_req & ~supply_bad & ~ov_det;
  wire active     = (st == S_RAMP) || (st == S_PG1W) || (st == S_PG2W) ||
                    (st == S_PGIC) || (st == S_ON);
  wire cb_trip    = ilim_act && (cb == CBW'(CB_TICKS - 1));
  wire done       = (tcnt == lim);

  assign gate_en = active;

  always_comb begin
    case (st)
      S_PG2W:  lim = {1'b0, nominal, 1'b0} - TW'(1);
      S_PGIC:  lim = {nominal, 2'b00} - TW'(1);
      S_RETRY: lim = (rk == RK_4X) ? ({nominal, 2'b00} - TW'(1))
                                   : ({2'b00, nominal} - TW'(1));
      default: lim = {2'b00, nominal} - TW'(1);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st            <= S_OFF;
      rk            <= RK_1X;
      tcnt          <= '0;
      cb            <= '0;
      boot          <= 1'b1;
      on_bit        <= 1'b0;
      on_q          <= 1'b0;
      pg1           <= 1'b0;
      pg2           <= 1'b0;
      flt_ov        <= 1'b0;
      flt_uv        <= 1'b0;
      flt_oc        <= 1'b0;
      flt_pbad      <= 1'b0;
      gate_fast_off <= 1'b0;
    end else begin
      on_q          <= on_in;
      flt_ov        <= 1'b0;
      flt_uv        <= 1'b0;
      flt_oc        <= 1'b0;
      flt_pbad      <= 1'b0;
      gate_fast_off <= 1'b0;
      tcnt          <= tcnt + TW'(1);
      cb            <= (active && ilim_act && !cb_trip) ? cb + CBW'(1) : '0;
      if (!boot) on_bit <= on_eff;

      if (active) begin
        if (off_req) begin
          st <= S_OFF; pg1 <= 1'b0; pg2 <= 1'b0; tcnt <= '0;
        end else if (supply_bad) begin
          st <= S_RETRY; rk <= RK_1X; flt_uv <= 1'b1;
          pg1 <= 1'b0; pg2 <= 1'b0; tcnt <= '0;
        end else if (ov_det) begin
          st <= S_RETRY; rk <= RK_OV; flt_ov <= 1'b1; tcnt <= '0;
        end else if (short_det) begin
          st <= S_RETRY; rk <= RK_4X; flt_oc <= 1'b1; gate_fast_off <= 1'b1;
          pg1 <= 1'b0; pg2 <= 1'b0; tcnt <= '0;
        end else if (cb_trip) begin
          st <= S_RETRY; rk <= RK_4X; flt_oc <= 1'b1;
          pg1 <= 1'b0; pg2 <= 1'b0; tcnt <= '0;
        end else begin
          case (st)
            S_RAMP: if (gate_high && drain_low) begin
              st <= S_PG1W; tcnt <= '0;
            end
            S_PG1W: if (done) begin
              pg1 <= 1'b1; st <= S_PG2W; tcnt <= '0;
            end
            S_PG2W: if (done) begin
              pg2 <= 1'b1; st <= S_PGIC; tcnt <= '0;
            end
            S_PGIC: begin
              if (!pgood_in_n) st <= S_ON;
              else if (done) begin
                st <= S_RETRY; rk <= RK_1X; flt_pbad <= 1'b1;
                pg1 <= 1'b0; pg2 <= 1'b0; tcnt <= '0;
              end
            end
            default: ;
          endcase
        end
      end else begin
        case (st)
          S_OFF: begin
            pg1 <= 1'b0;
            pg2 <= 1'b0;
            if (boot) begin
              if (done) begin
                boot <= 1'b0; on_bit <= on_in; tcnt <= '0;
              end
            end else if (ok) begin
              st <= S_START; tcnt <= '0;
            end
          end
          S_START: begin
            if (!ok) begin
              st <= S_OFF; tcnt <= '0;
            end else if (done) begin
              st <= S_RAMP; tcnt <= '0;
            end
          end
          S_RETRY: begin
            if (off_req) begin
              st <= S_OFF; tcnt <= '0;
            end else if (rk == RK_OV) begin
              if (!ov_det) begin
                st <= ok ? S_RAMP : S_OFF; tcnt <= '0;
              end
            end else if (done) begin
              st <= ok ? S_RAMP : S_OFF; tcnt <= '0;
            end
          end
          default: begin
            st <= S_OFF; tcnt <= '0;
          end
        endcase
      end
    end
  end

  p_gate_needs_ok_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_en) |-> $past(ok));

  p_pg_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pg2 |-> pg1);

  p_pg1_with_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pg1) |-> gate_en);

  p_pbad_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    flt_pbad |-> (!pg1 && !pg2 && !gate_en && $past(pgood_in_n)));

  p_fast_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    gate_fast_off |-> (!gate_en && flt_oc && !pg1));

  p_ov_keeps_pg_r11: assert property (@(posedge clk) disable iff (!rst_n)
    flt_ov |-> (!gate_en && pg1 == $past(pg1) && pg2 == $past(pg2)));

  p_disable_off_r12: assert property (@(posedge clk) disable iff (!rst_n)
    disable_in |=> !gate_en);

  p_fault_excl_r13: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({flt_ov, flt_uv, flt_oc, flt_pbad}));

  p_oc_single_r13: assert property (@(posedge clk) disable iff (!rst_n)
    flt_oc |=> !flt_oc);

  p_breaker_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_oc && !gate_fast_off) |-> $past(ilim_act));
endmodule

// File: tb/hotswap_seq_test.sv
module hotswap_seq_test;
  localparam int CW = 8;
  localparam int CB = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic uvlo_ok = 1'b1, uv_det = 1'b0, ov_det = 1'b0;
  logic gate_high = 1'b0, drain_low = 1'b0, ilim_act = 1'b0, short_det = 1'b0;
  logic on_in = 1'b1, disable_in = 1'b0, pgood_in_n = 1'b1;
  logic [CW-1:0] nominal = 8'd3;
  logic gate_en, gate_fast_off, pg1, pg2, flt_ov, flt_uv, flt_oc, flt_pbad;

  int checks = 0, fails = 0, cycles = 0;
  int n_oc = 0, n_pb = 0, n_uv = 0, n_ov = 0;

  hotswap_seq #(.CW(CW), .CB_TICKS(CB)) uut (
    .clk(clk), .rst_n(rst_n), .uvlo_ok(uvlo_ok), .uv_det(uv_det), .ov_det(ov_det),
    .gate_high(gate_high), .drain_low(drain_low), .ilim_act(ilim_act),
    .short_det(short_det), .on_in(on_in), .disable_in(disable_in),
    .pgood_in_n(pgood_in_n), .nominal(nominal), .gate_en(gate_en),
    .gate_fast_off(gate_fast_off), .pg1(pg1), .pg2(pg2), .flt_ov(flt_ov),
    .flt_uv(flt_uv), .flt_oc(flt_oc), .flt_pbad(flt_pbad));

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (flt_oc)   n_oc <= n_oc + 1;
    if (flt_pbad) n_pb <= n_pb + 1;
    if (flt_uv)   n_uv <= n_uv + 1;
    if (flt_ov)   n_ov <= n_ov + 1;
    if (cycles > 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog: actual %0d cycles, expected under 150000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  function automatic int d_start(int n); return 2*n + 1; endfunction
  function automatic int d_edge(int n);  return n + 1;   endfunction
  function automatic int d_pg2(int n);   return 2*n;     endfunction
  function automatic int d_wd(int n);    return 4*n;     endfunction

  task automatic chk(string rq, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", rq, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic sig(int w);
    case (w)
      0: return gate_en;
      1: return pg1;
      2: return pg2;
      3: return flt_pbad;
      default: return flt_oc;
    endcase
  endfunction

  task automatic measure(int w, logic v, output int c);
    c = 0;
    do begin
      step();
      c++;
    end while (sig(w) != v && c < 5000);
  endtask

  task automatic do_reset(int n, logic on_lvl, logic uvok);
    rst_n = 1'b0;
    nominal = CW'(n);
    on_in = on_lvl; uvlo_ok = uvok; uv_det = 0; ov_det = 0;
    gate_high = 0; drain_low = 0; ilim_act = 0; short_det = 0;
    disable_in = 0; pgood_in_n = 1;
    repeat (3) step();
    chk("R1 reset gate", gate_en, 0);
    chk("R1 reset pg", {pg1, pg2}, 0);
    chk("R1 reset faults", {flt_ov, flt_uv, flt_oc, flt_pbad, gate_fast_off}, 0);
    rst_n = 1'b1;
  endtask

  task automatic reach_on(int n);
    repeat (4*n + 4) step();
  endtask

  task automatic run_iter(int n);
    int c, c2, k, len;
    do_reset(n, 1'b1, 1'b1);
    measure(0, 1'b1, c); chk("R1 power-up gate delay", c, d_start(n));

    gate_high = 1; drain_low = 1;
    measure(1, 1'b1, c); chk("R4 pg1 delay", c, d_edge(n));
    measure(2, 1'b1, c); chk("R5 pg2 delay", c, d_pg2(n));
    chk("R5 pg1 still set", pg1, 1);
    measure(3, 1'b1, c); chk("R6 watchdog expiry", c, d_wd(n));
    chk("R6 gate off on power-bad", gate_en, 0);
    chk("R6 pg cleared on power-bad", {pg1, pg2}, 0);
    measure(0, 1'b1, c); chk("R10 retry after power-bad", c, n);

    measure(1, 1'b1, c); chk("R4 pg1 delay on retry", c, d_edge(n));
    pgood_in_n = 0;
    measure(2, 1'b1, c); chk("R5 pg2 delay on retry", c, d_pg2(n));
    k = n_pb;
    repeat (4*n + 3) step();
    chk("R6 good input keeps gate", gate_en, 1);
    chk("R6 no power-bad", n_pb, k);

    len = 1 + int'($urandom % (CB - 1));
    k = n_oc;
    ilim_act = 1;
    repeat (len) step();
    ilim_act = 0;
    repeat (2) step();
    chk("R7 short limit episode ignored gate", gate_en, 1);
    chk("R7 short limit episode no fault", n_oc, k);
    ilim_act = 1;
    measure(4, 1'b1, c); chk("R7 breaker time", c, CB);
    chk("R7 gate off after trip", gate_en, 0);
    chk("R7 pg cleared after trip", pg1, 0);
    ilim_act = 0;
    step();
    chk("R13 oc pulse single", flt_oc, 0);
    measure(0, 1'b1, c2); chk("R9 retry after breaker", c2 + 1, d_wd(n));
    reach_on(n);

    short_det = 1;
    step();
    short_det = 0;
    chk("R8 gate off at once", gate_en, 0);
    chk("R8 fast pull-down", gate_fast_off, 1);
    chk("R8 oc reported", flt_oc, 1);
    chk("R8 pg cleared", {pg1, pg2}, 0);
    measure(0, 1'b1, c); chk("R9 retry after short", c, d_wd(n));
    reach_on(n);

    ov_det = 1;
    step();
    chk("R11 gate off", gate_en, 0);
    chk("R11 ov reported", flt_ov, 1);
    chk("R11 pg kept", {pg1, pg2}, 2'b11);
    repeat (3) step();
    chk("R11 off while ov", gate_en, 0);
    ov_det = 0;
    measure(0, 1'b1, c); chk("R11 resume with no delay", c, 1);
    reach_on(n);

    uv_det = 1;
    step();
    uv_det = 0;
    chk("R10 uv reported", flt_uv, 1);
    chk("R10 gate off", gate_en, 0);
    chk("R10 pg cleared", {pg1, pg2}, 0);
    measure(0, 1'b1, c); chk("R10 retry after uv", c, n);
    reach_on(n);

    k = n_oc + n_pb + n_uv + n_ov;
    disable_in = 1;
    step();
    chk("R12 gate off", gate_en, 0);
    chk("R12 pg cleared", {pg1, pg2}, 0);
    repeat (4) step();
    chk("R12 stays off", gate_en, 0);
    chk("R12 no fault", n_oc + n_pb + n_uv + n_ov, k);
    disable_in = 0;
    measure(0, 1'b1, c); chk("R12 release delay", c, d_edge(n));
    reach_on(n);

    k = n_oc + n_pb + n_uv + n_ov;
    on_in = 0;
    step();
    chk("R3 falling edge gate off", gate_en, 0);
    chk("R3 falling edge pg cleared", pg1, 0);
    repeat (3) step();
    chk("R3 no fault on turn-off", n_oc + n_pb + n_uv + n_ov, k);
    on_in = 1;
    measure(0, 1'b1, c); chk("R3 rising edge delay", c, d_edge(n));

    do_reset(n, 1'b1, 1'b0);
    repeat (3*n + 4) step();
    chk("R2 lockout holds gate off", gate_en, 0);
    uvlo_ok = 1;
    measure(0, 1'b1, c); chk("R2 start after lockout clears", c, d_edge(n));
    disable_in = 1;
    step();
    disable_in = 0;
    step();
    ov_det = 1;
    step();
    ov_det = 0;
    c = 1;
    measure(0, 1'b1, c2); chk("R2 start-up wait restarts", c + c2, n + 2);

    do_reset(n, 1'b0, 1'b1);
    repeat (3*n + 4) step();
    chk("R1 on low at power-up keeps gate off", gate_en, 0);
    on_in = 1;
    measure(0, 1'b1, c); chk("R1 later rising edge starts", c, d_edge(n));
  endtask

  initial begin
    int seed;
    seed = $urandom(32'd20240611);
    @(negedge clk);
    run_iter(1);
    run_iter(2);
    for (int i = 0; i < 5; i++) run_iter(2 + int'($urandom % 6));
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule